// File: doc/BRIEF.md
# Byte-Serial Load/Store Sequencer

This block sits between a 32-bit core and an 8-bit-wide RAM of 128 KB. The core presents one memory request at a time: a 17-bit byte address, an access size (byte, halfword or word), a direction, a signed flag and, for stores, the data. The sequencer breaks the request into single-byte RAM transfers and runs them one after another. It raises a one-cycle completion pulse when the last byte is done.

Multi-byte values are kept big-endian. The most significant byte sits at the lowest address and is transferred first. Loads build the value from the bytes they read. Byte and halfword results are sign- or zero-extended to 32 bits according to the signed flag. The RAM read port has one cycle of latency, so each byte read takes an address cycle followed by a capture cycle. A store writes one byte per cycle.

Typical uses are word accesses to the program image at 0x0000 and the text input area at 0x1000. Another is byte-wide character stores into the output area at 0x1400.

Top module: `byte_ls_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `done` and `ram_we` are low.
- R2: A request is taken only when `busy` is low. A `req_valid` pulse seen while `busy` is high is dropped. It causes no RAM write and starts no later transfer.
- R3: Byte order is big-endian. Byte k of an n-byte access (k = 0 being the most significant) goes to or comes from address base+k. Bytes are transferred in ascending address order.
- R4: The size encoding is `req_size` 00 = byte, 01 = halfword, 10 or 11 = word. A store of n bytes drives `ram_we` in exactly the n cycles after acceptance. It writes only addresses base..base+n-1, using the low n bytes of `req_wdata`.
- R5: A load of n bytes uses 2n cycles after acceptance: an address cycle and then a capture cycle for each byte. `ram_we` stays low throughout.
- R6: Completion is reported in the cycle after the last write or capture. A store therefore reports at cycle n+1 after acceptance and a load at cycle 2n+1.
- R7: A byte load returns bits 31:8 as copies of bit 7 when `req_signed` is 1, and as zero when it is 0.
- R8: A halfword load returns bits 31:16 as copies of bit 15 when `req_signed` is 1, and as zero when it is 0.
- R9: A word load returns all four bytes, first byte in bits 31:24.
- R10: `done` is high for exactly one cycle. In the following cycle `busy` is low. `rdata` stays valid from `done` until the next request is taken.
- R11: Byte addresses wrap modulo 2^17, so an access starting near the top of memory continues at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_addr | input | 17 | Byte address of the first (most significant) byte |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| req_write | input | 1 | 1 = store, 0 = load |
| req_signed | input | 1 | Sign-extend byte/halfword loads |
| req_wdata | input | 32 | Store data, right-aligned |
| ram_addr | output | 17 | RAM byte address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte, one cycle after address |
| busy | output | 1 | Request in progress (includes the done cycle) |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Extended load result |

## Verification
The bench aims at the extension boundaries: byte 0x80 and halfword 0x8001 are loaded both signed and unsigned. A design that mixed up the signed flag or extended from the wrong bit would return 0x00000080 where 0xFFFFFF80 is due, or the reverse. It counts the exact cycles to completion for every size and direction, and logs every RAM write with its full address. This exposes an off-by-one in the read latency, a missing or extra byte, or little-endian ordering. A word store at 0x1FFFE checks that addresses wrap to 0 instead of writing past the top. A request pulsed mid-transfer must leave its target byte untouched.

// File: rtl/byte_ls_seq.sv
module byte_ls_seq #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic          req_signed,
  input  logic [31:0]   req_wdata,
  output logic [AW-1:0] ram_addr,
  output logic          ram_we,
  output logic [7:0]    ram_wdata,
  input  logic [7:0]    ram_rdata,
  output logic          busy,
  output logic          done,
  output logic [31:0]   rdata
);
  typedef enum logic [2:0] {S_IDLE, S_WR, S_RD, S_CAP, S_DONE} st_t;

  st_t          st;
  logic [AW-1:0] base;
  logic [1:0]   idx, last;
  logic [1:0]   sz;
  logic         sgn;
  logic [31:0]  wbuf, acc;
  logic [1:0]   req_last;
  logic [31:0]  req_aligned;

  always_comb begin
    case (req_size)
      2'b00:   begin req_last = 2'd0; req_aligned = {req_wdata[7:0], 24'd0}; end
      2'b01:   begin req_last = 2'd1; req_aligned = {req_wdata[15:0], 16'd0}; end
      default: begin req_last = 2'd3; req_aligned = req_wdata; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; base <= '0; idx <= '0; last <= '0;
      sz <= '0; sgn <= 1'b0; wbuf <= '0; acc <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          base <= req_addr; idx <= '0; last <= req_last;
          sz <= req_size; sgn <= req_signed; wbuf <= req_aligned; acc <= '0;
          st <= req_write ? S_WR : S_RD;
        end
        S_WR: begin
          wbuf <= {wbuf[23:0], 8'd0};
          idx  <= idx + 2'd1;
          if (idx == last) st <= S_DONE;
        end
        S_RD: st <= S_CAP;
        S_CAP: begin
          acc <= {acc[23:0], ram_rdata};
          idx <= idx + 2'd1;
          st  <= (idx == last) ? S_DONE : S_RD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ram_addr  = base + AW'(idx);
  assign ram_we    = (st == S_WR);
  assign ram_wdata = wbuf[31:24];
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);

  always_comb begin
    case (sz)
      2'b00:   rdata = {{24{sgn & acc[7]}}, acc[7:0]};
      2'b01:   rdata = {{16{sgn & acc[15]}}, acc[15:0]};
      default: rdata = acc;
    endcase
  end

  p_reset_quiet_r1: assert property (@(posedge clk) $rose(rst_n) |-> !busy && !done && !ram_we);
  p_hold_req_r2:    assert property (@(posedge clk) disable iff (!rst_n)
                      (busy && !done) |=> $stable(base) && $stable(sz));
  p_addr_step_r3:   assert property (@(posedge clk) disable iff (!rst_n)
                      (ram_we && $past(ram_we)) |-> ram_addr == $past(ram_addr) + AW'(1));
  p_we_store_r5:    assert property (@(posedge clk) disable iff (!rst_n)
                      ram_we |-> busy && !done);
  p_one_done_r10:   assert property (@(posedge clk) disable iff (!rst_n)
                      done |=> !done && !busy);
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
                      (!busy && $past(done)) |-> $stable(rdata));
endmodule

// File: tb/sim_byte_ls_seq.sv
module sim_byte_ls_seq;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_signed = 0;
  logic [16:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [16:0] ram_addr;
  logic ram_we, busy, done;
  logic [7:0] ram_wdata, ram_rdata;
  logic [31:0] rdata;
  logic [7:0] mem [0:255];
  logic [16:0] wlog [0:7];
  int wcnt = 0, n_chk = 0, n_fail = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  byte_ls_seq u0 (.clk, .rst_n, .req_valid, .req_addr, .req_size, .req_write,
    .req_signed, .req_wdata, .ram_addr, .ram_we, .ram_wdata, .ram_rdata,
    .busy, .done, .rdata);

  always @(posedge clk) begin
    if (ram_we) begin
      mem[ram_addr[7:0]] <= ram_wdata;
      if (wcnt < 8) wlog[wcnt] <= ram_addr;
      wcnt <= wcnt + 1;
    end
    ram_rdata <= mem[ram_addr[7:0]];
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic run(input logic [16:0] a, input logic [1:0] s, input logic w,
                     input logic sg, input logic [31:0] d, output int cyc);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_size = s; req_write = w; req_signed = sg; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    cyc = 1;
    while (!done && cyc < 50) begin @(negedge clk); cyc++; end
  endtask

  task automatic after_done();
    @(negedge clk);
    chk("R10 done width", {31'd0, done}, 0);
    chk("R10 busy after", {31'd0, busy}, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 done", {31'd0, done}, 0);
    chk("R1 we", {31'd0, ram_we}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 idle after release", {29'd0, busy, done, ram_we}, 0);
  endtask

  task automatic t_word_store();
    int c;
    wcnt = 0;
    run(17'h01400, 2'b10, 1, 0, 32'h12345678, c);
    chk("R6 store word cycles", c, 5);
    chk("R4 store word count", wcnt, 4);
    chk("R3 order", {mem[8'h00], mem[8'h01], mem[8'h02], mem[8'h03]}, 32'h12345678);
    chk("R3 addr first", {15'd0, wlog[0]}, 32'h1400);
    chk("R3 addr last", {15'd0, wlog[3]}, 32'h1403);
    after_done();
  endtask

  task automatic t_word_load();
    int c;
    mem[8'h10] = 8'hDE; mem[8'h11] = 8'hAD; mem[8'h12] = 8'hBE; mem[8'h13] = 8'hEF;
    wcnt = 0;
    run(17'h00010, 2'b11, 0, 1, 0, c);
    chk("R6 load word cycles", c, 9);
    chk("R9 word data", rdata, 32'hDEADBEEF);
    chk("R5 no writes on load", wcnt, 0);
    after_done();
    chk("R10 rdata held", rdata, 32'hDEADBEEF);
  endtask

  task automatic t_byte_load();
    int c;
    mem[8'h20] = 8'h80; mem[8'h21] = 8'h7F;
    run(17'h01020, 2'b00, 0, 1, 0, c);
    chk("R5 load byte cycles", c, 3);
    chk("R7 signed byte", rdata, 32'hFFFFFF80);
    run(17'h01020, 2'b00, 0, 0, 0, c);
    chk("R7 unsigned byte", rdata, 32'h00000080);
    run(17'h01021, 2'b00, 0, 1, 0, c);
    chk("R7 signed positive byte", rdata, 32'h0000007F);
  endtask

  task automatic t_half_load();
    int c;
    mem[8'h30] = 8'h80; mem[8'h31] = 8'h01;
    run(17'h00030, 2'b01, 0, 1, 0, c);
    chk("R5 load half cycles", c, 5);
    chk("R8 signed half", rdata, 32'hFFFF8001);
    run(17'h00030, 2'b01, 0, 0, 0, c);
    chk("R8 unsigned half", rdata, 32'h00008001);
  endtask

  task automatic t_small_store();
    int c;
    mem[8'h40] = 8'h11; mem[8'h41] = 8'h22; mem[8'h42] = 8'h33;
    wcnt = 0;
    run(17'h01441, 2'b00, 1, 0, 32'hAABBCC5A, c);
    chk("R6 store byte cycles", c, 2);
    chk("R4 byte store", {mem[8'h40], mem[8'h41], mem[8'h42]}, 24'h115A33);
    wcnt = 0;
    run(17'h00050, 2'b01, 1, 0, 32'hFFFFBEEF, c);
    chk("R4 half store count", wcnt, 2);
    chk("R3 half order", {mem[8'h50], mem[8'h51]}, 16'hBEEF);
  endtask

  task automatic t_busy_ignore();
    int c;
    mem[8'h60] = 8'h99;
    wcnt = 0;
    @(negedge clk);
    req_valid = 1; req_addr = 17'h00070; req_size = 2'b10; req_write = 1; req_wdata = 32'h01020304;
    @(negedge clk);
    req_addr = 17'h00060; req_size = 2'b00; req_wdata = 32'h55;
    @(negedge clk);
    req_valid = 0;
    c = 2;
    while (!done && c < 50) begin @(negedge clk); c++; end
    after_done();
    repeat (3) @(negedge clk);
    chk("R2 dropped request", {24'd0, mem[8'h60]}, 32'h99);
    chk("R2 write count", wcnt, 4);
  endtask

  task automatic t_wrap();
    int c;
    wcnt = 0;
    run(17'h1FFFE, 2'b10, 1, 0, 32'hCAFEF00D, c);
    chk("R11 wrap addr 2", {15'd0, wlog[2]}, 32'h0);
    chk("R11 wrap addr 3", {15'd0, wlog[3]}, 32'h1);
    run(17'h1FFFE, 2'b10, 0, 0, 0, c);
    chk("R11 wrap load", rdata, 32'hCAFEF00D);
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    @(negedge clk);
    t_reset();
    t_word_store();
    t_word_load();
    t_byte_load();
    t_half_load();
    t_small_store();
    t_busy_ignore();
    t_wrap();
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule